// File: doc/BRIEF.md
# Return-From-Trap Sequencer

This block carries out the return-from-interrupt instruction of a 16-bit processor core. The decoder raises `start` together with the opcode field of the instruction. If the core is in supervisor mode, the block pops two words off the supervisor stack through a read port. The first word is the return PC and the second is the saved status word, which is the exact reverse of the order in which trap entry pushed them. Once both words are back, the block presents the new PC, the new status word and the new R6 value to the register file in a single commit cycle.

If the restored privilege bit selects user mode, the block swaps stacks at commit. The post-pop supervisor stack pointer goes to the supervisor shadow register, and R6 takes the user shadow value. A return to supervisor mode keeps R6 on the supervisor stack. The return PC is written as popped, so after a protection fault the faulting instruction runs again. If the instruction is issued from user mode, the block makes no memory access and raises a privilege-violation pulse instead.

The read port is split into two valid/ready channels. On the request channel, `rd_valid` and `rd_addr` stay asserted and unchanged until the cycle in which `rd_ready` is high, and one word is requested per handshake. On the response channel, the block raises `rsp_ready` only while it waits for a word, and it takes `rsp_data` in the cycle in which `rsp_valid` and `rsp_ready` are both high. The memory may stall either channel for any number of cycles.

Top module: `rti_seq`

## Requirements
- R1: A `start` pulse begins an operation only when the block is idle and `opcode` equals 4'b1000; any other `start` is ignored.
- R2: If status bit 15 of `psr_in` is 1 (user mode) when a valid start is taken, the block asserts `priv_viol` for exactly the next cycle, makes no read request and asserts no load strobe.
- R3: The first read goes to address R6 (the PC word) and the second goes to R6+2 (the status word), both computed modulo 2^16.
- R4: `rd_valid` stays high with `rd_addr` unchanged until it is accepted by `rd_ready`, and exactly two requests are made per operation.
- R5: `rsp_ready` is high only while a requested word is outstanding, and no load strobe is asserted before the status word has been taken.
- R6: `pc_ld`, `psr_ld`, `r6_ld` and `done` rise together for a single cycle, one cycle after the status word is taken, with `pc_out` equal to the first popped word.
- R7: `psr_out` carries bit 15 and bits 2:0 (N, Z, P) of the popped status word, and every other bit of `psr_out` is zero.
- R8: If bit 15 of the popped status word is 1, the commit also asserts `ssp_ld` with `ssp_out` = R6+4, and `r6_out` equals `usp_in`.
- R9: If bit 15 of the popped status word is 0, `ssp_ld` stays low and `r6_out` equals R6+4.
- R10: `busy` is high from the cycle after a start is accepted up to and including the commit cycle, and low otherwise.
- R11: A stack pointer at 16'hFFFE wraps, so the status word is read from 16'h0000 and the committed stack pointer is 16'h0002.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Strobe from the decoder |
| opcode | input | 4 | Opcode field of the decoded instruction |
| psr_in | input | 16 | Current status word; bit 15 is 1 for user mode |
| r6_in | input | 16 | Current R6 (the supervisor stack pointer) |
| usp_in | input | 16 | User stack-pointer shadow register |
| rd_valid | output | 1 | Read request valid |
| rd_ready | input | 1 | Read request accepted |
| rd_addr | output | 16 | Read address |
| rsp_valid | input | 1 | Read data valid |
| rsp_data | input | 16 | Read data |
| rsp_ready | output | 1 | Block is waiting for read data |
| pc_ld | output | 1 | Load strobe for the PC |
| pc_out | output | 16 | New PC value |
| psr_ld | output | 1 | Load strobe for the status word |
| psr_out | output | 16 | New status word |
| r6_ld | output | 1 | Load strobe for R6 |
| r6_out | output | 16 | New R6 value |
| ssp_ld | output | 1 | Load strobe for the supervisor SP shadow register |
| ssp_out | output | 16 | New supervisor SP shadow value |
| busy | output | 1 | Operation in progress |
| done | output | 1 | Commit pulse |
| priv_viol | output | 1 | Instruction issued from user mode |

## Verification
The bench builds the block with its default parameters: a 16-bit word, a pop step of 2, privilege at bit 15 and a three-bit condition field. With these values the bench can place the stack pointer at 16'hFFFE and so reach the address wrap. It also covers both values of the restored privilege bit, and it sends status words whose middle bits are all ones, which must be dropped. The bench memory inserts 0 to 3 stall cycles on each channel. It also repeats the start pulse in the middle of an operation and sends a wrong opcode, and neither may disturb the run in progress.

// File: rtl/rti_pkg.sv
package rti_pkg;
  typedef enum logic [2:0] {
    S_IDLE,
    S_REQ_PC,
    S_WAIT_PC,
    S_REQ_ST,
    S_WAIT_ST,
    S_COMMIT,
    S_FAULT
  } rti_state_e;
endpackage

// File: rtl/rti_ctrl.sv
module rti_ctrl
  import rti_pkg::*;
#(
  parameter int OPC_W   = 4,
  parameter logic [OPC_W-1:0] OPC_RET = 4'b1000
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [OPC_W-1:0] opcode,
  input  logic             user_mode,
  input  logic             rd_ready,
  input  logic             rsp_valid,
  output rti_state_e       state,
  output logic             accept,
  output logic             adv_sp,
  output logic             cap_pc,
  output logic             cap_st
);
  rti_state_e nxt;
  logic       go;

  assign go     = (state == S_IDLE) && start && (opcode == OPC_RET);
  assign accept = go && !user_mode;
  assign adv_sp = ((state == S_REQ_PC) || (state == S_REQ_ST)) && rd_ready;
  assign cap_pc = (state == S_WAIT_PC) && rsp_valid;
  assign cap_st = (state == S_WAIT_ST) && rsp_valid;

  always_comb begin
    nxt = state;
    unique case (state)
      S_IDLE:    if (go) nxt = user_mode ? S_FAULT : S_REQ_PC;
      S_REQ_PC:  if (rd_ready) nxt = S_WAIT_PC;
      S_WAIT_PC: if (rsp_valid) nxt = S_REQ_ST;
      S_REQ_ST:  if (rd_ready) nxt = S_WAIT_ST;
      S_WAIT_ST: if (rsp_valid) nxt = S_COMMIT;
      S_COMMIT:  nxt = S_IDLE;
      S_FAULT:   nxt = S_IDLE;
      default:   nxt = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) state <= S_IDLE;
    else        state <= nxt;
  end
endmodule

// File: rtl/rti_sp.sv
module rti_sp #(
  parameter int DW      = 16,
  parameter int SP_STEP = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [DW-1:0] load_val,
  input  logic          adv,
  output logic [DW-1:0] sp
);
  localparam logic [DW-1:0] STEP = DW'(SP_STEP);

  always_ff @(posedge clk) begin
    if (!rst_n)    sp <= '0;
    else if (load) sp <= load_val;
    else if (adv)  sp <= sp + STEP;
  end
endmodule

// File: rtl/rti_commit.sv
module rti_commit #(
  parameter int DW       = 16,
  parameter int PRIV_BIT = 15,
  parameter int CC_W     = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cap_pc,
  input  logic          cap_st,
  input  logic [DW-1:0] word,
  input  logic [DW-1:0] sp,
  input  logic [DW-1:0] usp_in,
  output logic [DW-1:0] pc_out,
  output logic [DW-1:0] psr_out,
  output logic [DW-1:0] r6_out,
  output logic          to_user
);
  logic [DW-1:0] st_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pc_out <= '0;
      st_q   <= '0;
    end else begin
      if (cap_pc) pc_out <= word;
      if (cap_st) st_q   <= word;
    end
  end

  for (genvar i = 0; i < DW; i++) begin : g_psr
    if ((i == PRIV_BIT) || (i < CC_W)) begin : g_keep
      assign psr_out[i] = st_q[i];
    end else begin : g_drop
      assign psr_out[i] = st_q[i] & 1'b0;
    end
  end

  assign to_user = st_q[PRIV_BIT];
  assign r6_out  = to_user ? usp_in : sp;
endmodule

// File: rtl/rti_seq.sv
module rti_seq
  import rti_pkg::*;
#(
  parameter int DW       = 16,
  parameter int OPC_W    = 4,
  parameter logic [OPC_W-1:0] OPC_RET = 4'b1000,
  parameter int PRIV_BIT = 15,
  parameter int CC_W     = 3,
  parameter int SP_STEP  = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [OPC_W-1:0] opcode,
  input  logic [DW-1:0]    psr_in,
  input  logic [DW-1:0]    r6_in,
  input  logic [DW-1:0]    usp_in,
  output logic             rd_valid,
  input  logic             rd_ready,
  output logic [DW-1:0]    rd_addr,
  input  logic             rsp_valid,
  input  logic [DW-1:0]    rsp_data,
  output logic             rsp_ready,
  output logic             pc_ld,
  output logic [DW-1:0]    pc_out,
  output logic             psr_ld,
  output logic [DW-1:0]    psr_out,
  output logic             r6_ld,
  output logic [DW-1:0]    r6_out,
  output logic             ssp_ld,
  output logic [DW-1:0]    ssp_out,
  output logic             busy,
  output logic             done,
  output logic             priv_viol
);
  rti_state_e    state;
  logic          accept, adv_sp, cap_pc, cap_st, to_user;
  logic [DW-1:0] sp;

  rti_ctrl #(.OPC_W(OPC_W), .OPC_RET(OPC_RET)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .start(start), .opcode(opcode),
    .user_mode(psr_in[PRIV_BIT]), .rd_ready(rd_ready), .rsp_valid(rsp_valid),
    .state(state), .accept(accept), .adv_sp(adv_sp),
    .cap_pc(cap_pc), .cap_st(cap_st)
  );

  rti_sp #(.DW(DW), .SP_STEP(SP_STEP)) u_sp (
    .clk(clk), .rst_n(rst_n), .load(accept), .load_val(r6_in),
    .adv(adv_sp), .sp(sp)
  );

  rti_commit #(.DW(DW), .PRIV_BIT(PRIV_BIT), .CC_W(CC_W)) u_commit (
    .clk(clk), .rst_n(rst_n), .cap_pc(cap_pc), .cap_st(cap_st),
    .word(rsp_data), .sp(sp), .usp_in(usp_in),
    .pc_out(pc_out), .psr_out(psr_out), .r6_out(r6_out), .to_user(to_user)
  );

  assign rd_valid  = (state == S_REQ_PC) || (state == S_REQ_ST);
  assign rd_addr   = sp;
  assign rsp_ready = (state == S_WAIT_PC) || (state == S_WAIT_ST);
  assign done      = (state == S_COMMIT);
  assign pc_ld     = done;
  assign psr_ld    = done;
  assign r6_ld     = done;
  assign ssp_ld    = done && to_user;
  assign ssp_out   = sp;
  assign busy      = (state != S_IDLE) && (state != S_FAULT);
  assign priv_viol = (state == S_FAULT);
endmodule

// File: rtl/rti_seq_chk.sv
module rti_seq_chk #(
  parameter int DW       = 16,
  parameter int PRIV_BIT = 15,
  parameter int CC_W     = 3
) (
  input logic          clk,
  input logic          rst_n,
  input logic          rd_valid,
  input logic          rd_ready,
  input logic [DW-1:0] rd_addr,
  input logic          rsp_ready,
  input logic          pc_ld,
  input logic          psr_ld,
  input logic [DW-1:0] psr_out,
  input logic          r6_ld,
  input logic [DW-1:0] r6_out,
  input logic          ssp_ld,
  input logic [DW-1:0] ssp_out,
  input logic [DW-1:0] usp_in,
  input logic          busy,
  input logic          done,
  input logic          priv_viol
);
  p_viol_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
    priv_viol |-> (!rd_valid && !pc_ld && !psr_ld && !r6_ld && !busy));
  p_viol_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
    priv_viol |=> !priv_viol);
  p_req_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && !rd_ready) |=> (rd_valid && $stable(rd_addr)));
  p_no_overlap_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !(rd_valid && rsp_ready));
  p_commit_group_r6: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (pc_ld && psr_ld && r6_ld && !rsp_ready && !rd_valid));
  p_done_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  p_done_after_rsp_r5: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(rsp_ready));
  p_psr_clean_r7: assert property (@(posedge clk) disable iff (!rst_n)
    psr_ld |-> (psr_out[PRIV_BIT-1:CC_W] == '0));
  p_user_swap_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (r6_ld && psr_out[PRIV_BIT]) |-> (ssp_ld && r6_out == usp_in));
  p_sup_keep_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (r6_ld && !psr_out[PRIV_BIT]) |-> (!ssp_ld && r6_out == ssp_out));
  p_idle_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!rd_valid && !rsp_ready && !done));
endmodule

bind rti_seq rti_seq_chk #(.DW(DW), .PRIV_BIT(PRIV_BIT), .CC_W(CC_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .rd_valid(rd_valid), .rd_ready(rd_ready),
  .rd_addr(rd_addr), .rsp_ready(rsp_ready), .pc_ld(pc_ld), .psr_ld(psr_ld),
  .psr_out(psr_out), .r6_ld(r6_ld), .r6_out(r6_out), .ssp_ld(ssp_ld),
  .ssp_out(ssp_out), .usp_in(usp_in), .busy(busy), .done(done),
  .priv_viol(priv_viol)
);

// File: tb/tb_rti_seq.sv
module tb_rti_seq;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [3:0]  opcode = 4'h0;
  logic [15:0] psr_in = 16'h0, r6_in = 16'h0, usp_in = 16'h0;
  logic        rd_valid, rd_ready = 1'b0, rsp_valid = 1'b0, rsp_ready;
  logic [15:0] rd_addr, rsp_data = 16'h0;
  logic        pc_ld, psr_ld, r6_ld, ssp_ld, busy, done, priv_viol;
  logic [15:0] pc_out, psr_out, r6_out, ssp_out;

  int n_chk = 0, n_fail = 0;
  int gnt_wait = 0, rsp_wait = 0;
  logic [15:0] mem [logic [15:0]];

  always #2.5 clk = ~clk;

  rti_seq dut (
    .clk(clk), .rst_n(rst_n), .start(start), .opcode(opcode), .psr_in(psr_in),
    .r6_in(r6_in), .usp_in(usp_in), .rd_valid(rd_valid), .rd_ready(rd_ready),
    .rd_addr(rd_addr), .rsp_valid(rsp_valid), .rsp_data(rsp_data),
    .rsp_ready(rsp_ready), .pc_ld(pc_ld), .pc_out(pc_out), .psr_ld(psr_ld),
    .psr_out(psr_out), .r6_ld(r6_ld), .r6_out(r6_out), .ssp_ld(ssp_ld),
    .ssp_out(ssp_out), .busy(busy), .done(done), .priv_viol(priv_viol)
  );

  task automatic chk(input string rq, input string what,
                     input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%h expected=%h", rq, what, act, exp);
    end
  endtask

  // reference model: phase 0 idle, 1/3 request, 2/4 await data, 5 commit, 6 fault
  int          m_ph = 0;
  logic [15:0] m_sp = 0, m_pc = 0, m_st = 0;

  always @(posedge clk) begin
    if (!rst_n) m_ph = 0;
    else begin
      case (m_ph)
        0: if (start && opcode == 4'b1000) begin
             if (psr_in[15]) m_ph = 6;
             else begin m_sp = r6_in; m_ph = 1; end
           end
        1: if (rd_ready) begin m_sp = m_sp + 16'd2; m_ph = 2; end
        2: if (rsp_valid) begin m_pc = rsp_data; m_ph = 3; end
        3: if (rd_ready) begin m_sp = m_sp + 16'd2; m_ph = 4; end
        4: if (rsp_valid) begin m_st = rsp_data; m_ph = 5; end
        default: m_ph = 0;
      endcase
    end
  end

  // bench memory with stalls on both channels
  logic        pend = 1'b0;
  int          pcnt = 0, wcnt = 0;
  logic [15:0] paddr = 0;
  always @(posedge clk) begin
    logic acc, take;
    logic [15:0] a;
    acc  = rd_valid && rd_ready;
    take = rsp_valid && rsp_ready;
    a    = rd_addr;
    #1;
    if (take) begin rsp_valid = 1'b0; pend = 1'b0; end
    if (acc) begin
      pend = 1'b1; pcnt = rsp_wait; paddr = a; rd_ready = 1'b0; wcnt = 0;
    end else if (rd_valid) begin
      rd_ready = (wcnt >= gnt_wait); wcnt++;
    end else begin
      rd_ready = 1'b0; wcnt = 0;
    end
    if (pend && !rsp_valid && !acc) begin
      if (pcnt == 0) begin
        rsp_valid = 1'b1;
        rsp_data  = mem.exists(paddr) ? mem[paddr] : 16'hDEAD;
      end else pcnt--;
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      logic rv, com;
      rv  = (m_ph == 1 || m_ph == 3);
      com = (m_ph == 5);
      chk("R4", "rd_valid", 16'(rd_valid), 16'(rv));
      if (rv) chk("R3", "rd_addr", rd_addr, m_sp);
      chk("R5", "rsp_ready", 16'(rsp_ready), 16'(m_ph == 2 || m_ph == 4));
      chk("R6", "done", 16'(done), 16'(com));
      chk("R6", "load strobes", {13'b0, pc_ld, psr_ld, r6_ld}, {13'b0, {3{com}}});
      chk("R10", "busy", 16'(busy), 16'(m_ph >= 1 && m_ph <= 5));
      chk("R2", "priv_viol", 16'(priv_viol), 16'(m_ph == 6));
      if (com) begin
        chk("R6", "pc_out", pc_out, m_pc);
        chk("R7", "psr_out", psr_out, {m_st[15], 12'b0, m_st[2:0]});
        if (m_st[15]) begin
          chk("R8", "ssp_ld", 16'(ssp_ld), 16'd1);
          chk("R8", "ssp_out", ssp_out, m_sp);
          chk("R8", "r6_out", r6_out, usp_in);
        end else begin
          chk("R9", "ssp_ld", 16'(ssp_ld), 16'd0);
          chk("R9", "r6_out", r6_out, m_sp);
        end
      end else chk("R8", "ssp_ld idle", 16'(ssp_ld), 16'd0);
    end
  end

  task automatic step();
    @(posedge clk); #1;
  endtask

  // one return operation; rq names the requirement of the final stack check
  task automatic run_ret(input logic [15:0] sp0, pcw, stw, usp,
                         input int gw, rw, input bit poke, input string rq);
    logic [15:0] exp_r6;
    int guard;
    mem[sp0] = pcw;
    mem[sp0 + 16'd2] = stw;
    gnt_wait = gw; rsp_wait = rw;
    psr_in = 16'h0002; r6_in = sp0; usp_in = usp;
    opcode = 4'b1000; start = 1'b1;
    step();
    start = 1'b0; r6_in = 16'h1111;
    guard = 0;
    while (!done && guard < 60) begin
      if (poke && guard == 2) begin start = 1'b1; r6_in = 16'h4444; end
      else start = 1'b0;
      @(negedge clk); guard++;
      @(posedge clk); #1;
    end
    start = 1'b0;
    exp_r6 = stw[15] ? usp : (sp0 + 16'd4);
    @(negedge clk);
    chk(rq, "commit seen", 16'(done), 16'd1);
    chk(rq, "final r6_out", r6_out, exp_r6);
    chk("R6", "final pc_out", pc_out, pcw);
    step();
  endtask

  initial begin
    repeat (3) step();
    rst_n = 1'b1;
    @(negedge clk);
    chk("R10", "reset busy", 16'(busy), 16'd0);
    chk("R4", "reset rd_valid", 16'(rd_valid), 16'd0);
    chk("R6", "reset done", 16'(done), 16'd0);
    step();

    run_ret(16'h2FF0, 16'h3010, 16'h8005, 16'hFE00, 0, 0, 1'b0, "R8");
    run_ret(16'h2FE8, 16'h1234, 16'h0002, 16'hFE00, 3, 2, 1'b0, "R9");
    run_ret(16'h2FF6, 16'h3000, 16'h7FF9, 16'hABCD, 1, 3, 1'b1, "R9");
    run_ret(16'h2FF6, 16'h3002, 16'hFFFC, 16'hFDFE, 2, 0, 1'b1, "R8");
    run_ret(16'hFFFE, 16'h5556, 16'h0004, 16'hFE00, 0, 1, 1'b0, "R11");
    run_ret(16'hFFFE, 16'h2AAA, 16'h8001, 16'h0100, 3, 3, 1'b0, "R11");

    // R1: wrong opcode is ignored
    opcode = 4'b1001; r6_in = 16'h2FF0; start = 1'b1;
    step();
    start = 1'b0;
    @(negedge clk);
    chk("R1", "busy after wrong opcode", 16'(busy), 16'd0);
    chk("R1", "no request after wrong opcode", 16'(rd_valid), 16'd0);
    step();

    // R2: issued from user mode
    opcode = 4'b1000; psr_in = 16'h8004; start = 1'b1;
    step();
    start = 1'b0;
    @(negedge clk);
    chk("R2", "violation pulse", 16'(priv_viol), 16'd1);
    chk("R2", "no request in user mode", 16'(rd_valid), 16'd0);
    step();
    @(negedge clk);
    chk("R2", "violation ends", 16'(priv_viol), 16'd0);
    chk("R2", "no load after violation", {13'b0, pc_ld, psr_ld, r6_ld}, 16'd0);
    psr_in = 16'h0002;
    step();

    run_ret(16'h3000, 16'h3004, 16'h8002, 16'hFE00, 0, 0, 1'b0, "R8");
    repeat (4) step();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule